// File: doc/BRIEF.md
# Audio Decoder Front-End Serial Control and Status Slave

This block sits between a two-wire serial host (I2C, standard mode) and the control inputs of an audio-decoder front end. The host loads five small control entries that set input attenuation, two stereo-separation trims, output-routing mode bits and test bits. It can also read one status byte built from the live detector flags of the front end. All register fields appear in parallel on dedicated output ports, so the analog and demodulation logic reads them without any handshake.

The slave answers the write address byte 0x84 and the read address byte 0x85. A write carries a sub-address byte followed by any number of data bytes. After each data byte the sub-address steps forward by one, modulo 16, so one transfer can load several entries. A read streams the status byte for as long as the host keeps acknowledging. The status byte carries a flag that is set by reset and cleared once the host has clocked its acknowledge bit after a status byte.

The two bus lines are resynchronised to the system clock. The slave pulls SDA low (`sda_oe` = 1) only for an acknowledge bit or a zero data bit. A pull-up is assumed outside the block.

Top module: `avd_i2c_regfile`

## Requirements
- R1: A transfer whose first byte after a start is 0x84 is acknowledged (SDA low in the ninth bit). The next byte is taken as a sub-address.
- R2: A transfer whose first byte is 0x85 is acknowledged, and the slave then drives the status byte MSB first.
- R3: Any other first byte is not acknowledged. All later bytes up to the next start or stop are ignored and not acknowledged, and no entry changes.
- R4: Only bits [3:0] of the sub-address byte select an entry. Entries 0 to 4 exist. A data byte aimed at entries 5 to 15 is acknowledged and changes nothing.
- R5: Within one write, each data byte goes to the current sub-address, and the sub-address then advances by one (modulo 16).
- R6: After reset the entries hold: entry0 0x00, entry1 0x1F, entry2 0x1F, entry3 0x01 (mute released), entry4 0x09 (attenuation 9). All test bits are 0.
- R7: Field positions are as follows. entry0: [7] test_dac, [6] test_mon, [2:0] spare_tst[4:2]. entry1: [5:0] sep_hi_trim. entry2: [5:0] sep_lo_trim. entry3: [7] spare_tst[0], [6] spare_tst[1], [5] nr_sel, [4] force_mono, [3] sap_cond, [0] mute_off. entry4: [7] in_lvl_sel, [5] att_bypass, [4] force_st, [3:0] att_lvl. All other bits are unused.
- R8: The status byte is {det_sap, det_noise, 0, 0, 0, 0, por_flag, det_stereo}, with bit 7 first. The detector flags are sampled when the byte is loaded for sending.
- R9: por_flag reads 1 after reset. It clears once the host clocks its acknowledge bit after a status byte, and it stays 0 until the next reset.
- R10: sda_oe changes only while SCL is low, so read data and acknowledge bits are stable across the SCL high phase.
- R11: A stop releases SDA and ends any burst. A repeated start restarts the address phase, so the host can write a sub-address and then read without a stop.
- R12: While the host acknowledges each status byte, a fresh status byte follows. A host not-acknowledge ends the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| det_stereo | input | 1 | Stereo pilot detected |
| det_sap | input | 1 | Second-program carrier detected |
| det_noise | input | 1 | Excess noise on second program |
| test_dac | output | 1 | DAC test mode |
| test_mon | output | 1 | Filter monitor test mode |
| spare_tst | output | 5 | Spare test bits |
| sep_hi_trim | output | 6 | High-frequency separation trim |
| sep_lo_trim | output | 6 | Low-frequency separation trim |
| nr_sel | output | 1 | Noise-reduction input selects second program |
| force_mono | output | 1 | Forced mono |
| sap_cond | output | 1 | Second program output without carrier detection |
| mute_off | output | 1 | 1 releases the output mute |
| force_st | output | 1 | Forced stereo |
| att_bypass | output | 1 | Bypass input level stage |
| in_lvl_sel | output | 1 | Input standard level select |
| att_lvl | output | 4 | Input attenuation setting |

## Verification
The hardest case to reach is the status stream across byte boundaries. The power-on flag must show in the first byte and be gone in the second byte of the same read, and this happens only if the slave honours the host's acknowledge bit. The stimulus reads two bytes back to back, acknowledging the first and not the second. It also chains a sub-address write into a read through a repeated start. A long burst that runs from entry 3 past entry 4 into non-existent entries shows that sub-address auto-increment and the ignoring of out-of-range entries work together.

// File: rtl/avd_pkg.sv
package avd_pkg;

  localparam int unsigned NUM_ENTRIES = 5;
  localparam int unsigned SUB_W       = 4;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned FLAT_W      = NUM_ENTRIES * BYTE_W;

  localparam logic [5:0] TRIM_RESET = 6'h1F;
  localparam logic [3:0] ATT_RESET  = 4'd9;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_WR,
    PH_RD,
    PH_SKIP
  } phase_e;

  function automatic logic [7:0] entry_default(input int unsigned idx);
    case (idx)
      1, 2:    entry_default = {2'b00, TRIM_RESET};
      3:       entry_default = 8'h01;
      4:       entry_default = {4'h0, ATT_RESET};
      default: entry_default = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] entry_mask(input int unsigned idx);
    case (idx)
      0:       entry_mask = 8'hC7;
      1, 2:    entry_mask = 8'h3F;
      3:       entry_mask = 8'hF9;
      4:       entry_mask = 8'hBF;
      default: entry_mask = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/avd_bus_sync.sv
module avd_bus_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_pipe_q, scl_pipe_d;
  logic [MSB:0] sda_pipe_q, sda_pipe_d;
  logic         scl_last_q, sda_last_q;

  always_comb begin
    scl_pipe_d = {scl_pipe_q[MSB-1:0], scl_i};
    sda_pipe_d = {sda_pipe_q[MSB-1:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_last_q <= 1'b1;
      sda_last_q <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_last_q <= scl_pipe_q[MSB];
      sda_last_q <= sda_pipe_q[MSB];
    end
  end

  assign scl_s     = scl_pipe_q[MSB];
  assign sda_s     = sda_pipe_q[MSB];
  assign scl_rise  = scl_s & ~scl_last_q;
  assign scl_fall  = ~scl_s & scl_last_q;
  assign start_det = scl_s & scl_last_q & sda_last_q & ~sda_s;
  assign stop_det  = scl_s & scl_last_q & ~sda_last_q & sda_s;

endmodule

// File: rtl/avd_i2c_engine.sv
module avd_i2c_engine
  import avd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h42
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       status_byte,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [SUB_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic             rd_done
);

  localparam logic [3:0] LAST_BIT = 4'd8;

  phase_e           phase_q, phase_d;
  logic [3:0]       bitcnt_q, bitcnt_d;
  logic             ack_q, ack_d;
  logic [7:0]       shreg_q, shreg_d;
  logic [6:0]       txreg_q, txreg_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             rw_q, rw_d;
  logic             oe_q, oe_d;
  logic             nack_q, nack_d;
  logic             wr_en_q, wr_en_d;
  logic [SUB_W-1:0] wr_addr_q, wr_addr_d;
  logic [7:0]       wr_data_q, wr_data_d;
  logic             rd_done_q, rd_done_d;

  always_comb begin
    phase_d   = phase_q;
    bitcnt_d  = bitcnt_q;
    ack_d     = ack_q;
    shreg_d   = shreg_q;
    txreg_d   = txreg_q;
    sub_d     = sub_q;
    rw_d      = rw_q;
    oe_d      = oe_q;
    nack_d    = nack_q;
    wr_en_d   = 1'b0;
    wr_addr_d = wr_addr_q;
    wr_data_d = wr_data_q;
    rd_done_d = 1'b0;

    if (stop_det) begin
      phase_d  = PH_IDLE;
      bitcnt_d = '0;
      ack_d    = 1'b0;
      oe_d     = 1'b0;
    end else if (start_det) begin
      phase_d  = PH_ADDR;
      bitcnt_d = '0;
      ack_d    = 1'b0;
      oe_d     = 1'b0;
    end else if (scl_rise) begin
      case (phase_q)
        PH_ADDR, PH_SUB, PH_WR: begin
          if (!ack_q && bitcnt_q < LAST_BIT) begin
            shreg_d  = {shreg_q[6:0], sda_s};
            bitcnt_d = bitcnt_q + 4'd1;
          end
        end
        PH_RD: begin
          if (ack_q) begin
            nack_d    = sda_s;
            rd_done_d = 1'b1;
          end else begin
            bitcnt_d = bitcnt_q + 4'd1;
          end
        end
        default: ;
      endcase
    end else if (scl_fall) begin
      case (phase_q)
        PH_ADDR: begin
          if (ack_q) begin
            ack_d    = 1'b0;
            bitcnt_d = '0;
            if (rw_q) begin
              phase_d = PH_RD;
              txreg_d = status_byte[6:0];
              oe_d    = ~status_byte[7];
            end else begin
              phase_d = PH_SUB;
              oe_d    = 1'b0;
            end
          end else if (bitcnt_q == LAST_BIT) begin
            if (shreg_q[7:1] == DEV_ADDR) begin
              ack_d = 1'b1;
              oe_d  = 1'b1;
              rw_d  = shreg_q[0];
            end else begin
              phase_d = PH_SKIP;
            end
          end
        end
        PH_SUB: begin
          if (ack_q) begin
            ack_d    = 1'b0;
            oe_d     = 1'b0;
            bitcnt_d = '0;
            phase_d  = PH_WR;
          end else if (bitcnt_q == LAST_BIT) begin
            sub_d = shreg_q[SUB_W-1:0];
            ack_d = 1'b1;
            oe_d  = 1'b1;
          end
        end
        PH_WR: begin
          if (ack_q) begin
            ack_d    = 1'b0;
            oe_d     = 1'b0;
            bitcnt_d = '0;
            sub_d    = sub_q + 1'b1;
          end else if (bitcnt_q == LAST_BIT) begin
            wr_en_d   = 1'b1;
            wr_addr_d = sub_q;
            wr_data_d = shreg_q;
            ack_d     = 1'b1;
            oe_d      = 1'b1;
          end
        end
        PH_RD: begin
          if (ack_q) begin
            ack_d = 1'b0;
            if (nack_q) begin
              phase_d = PH_SKIP;
              oe_d    = 1'b0;
            end else begin
              bitcnt_d = '0;
              txreg_d  = status_byte[6:0];
              oe_d     = ~status_byte[7];
            end
          end else if (bitcnt_q == LAST_BIT) begin
            oe_d  = 1'b0;
            ack_d = 1'b1;
          end else begin
            txreg_d = {txreg_q[5:0], 1'b0};
            oe_d    = ~txreg_q[6];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      bitcnt_q  <= '0;
      ack_q     <= 1'b0;
      shreg_q   <= '0;
      txreg_q   <= '0;
      sub_q     <= '0;
      rw_q      <= 1'b0;
      oe_q      <= 1'b0;
      nack_q    <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      rd_done_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      bitcnt_q  <= bitcnt_d;
      ack_q     <= ack_d;
      shreg_q   <= shreg_d;
      txreg_q   <= txreg_d;
      sub_q     <= sub_d;
      rw_q      <= rw_d;
      oe_q      <= oe_d;
      nack_q    <= nack_d;
      wr_en_q   <= wr_en_d;
      wr_addr_q <= wr_addr_d;
      wr_data_q <= wr_data_d;
      rd_done_q <= rd_done_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
  assign rd_done = rd_done_q;

endmodule

// File: rtl/avd_ctrl_regs.sv
module avd_ctrl_regs
  import avd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SUB_W-1:0]  wr_addr,
  input  logic [7:0]        wr_data,
  output logic [FLAT_W-1:0] entry_flat
);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    logic [7:0] val_q, val_d;
    logic       hit;

    assign hit = wr_en && (wr_addr == SUB_W'(g));

    always_comb begin
      val_d = val_q;
      if (hit) val_d = wr_data & entry_mask(g);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= entry_default(g);
      else        val_q <= val_d;
    end

    assign entry_flat[g*BYTE_W +: BYTE_W] = val_q;
  end

endmodule

// File: rtl/avd_i2c_regfile.sv
module avd_i2c_regfile
  import avd_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h42,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       det_stereo,
  input  logic       det_sap,
  input  logic       det_noise,
  output logic       test_dac,
  output logic       test_mon,
  output logic [4:0] spare_tst,
  output logic [5:0] sep_hi_trim,
  output logic [5:0] sep_lo_trim,
  output logic       nr_sel,
  output logic       force_mono,
  output logic       sap_cond,
  output logic       mute_off,
  output logic       force_st,
  output logic       att_bypass,
  output logic       in_lvl_sel,
  output logic [3:0] att_lvl
);

  logic [1:0]        rst_pipe_q;
  logic              rst_n_s;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en, rd_done;
  logic [SUB_W-1:0]  wr_addr;
  logic [7:0]        wr_data;
  logic [FLAT_W-1:0] entry_flat;
  logic [7:0]        status_byte;
  logic              por_q, por_d;
  logic [7:0]        e0, e1, e2, e3, e4;
  logic              unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  avd_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  avd_i2c_engine #(.DEV_ADDR(DEV_ADDR)) eng_i (
    .clk(clk), .rst_n(rst_n_s), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .status_byte(status_byte), .sda_oe(sda_oe), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_done(rd_done)
  );

  avd_ctrl_regs regs_i (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .entry_flat(entry_flat)
  );

  always_comb begin
    por_d = por_q;
    if (rd_done) por_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) por_q <= 1'b1;
    else          por_q <= por_d;
  end

  assign status_byte = {det_sap, det_noise, 4'b0000, por_q, det_stereo};

  assign e0 = entry_flat[0*BYTE_W +: BYTE_W];
  assign e1 = entry_flat[1*BYTE_W +: BYTE_W];
  assign e2 = entry_flat[2*BYTE_W +: BYTE_W];
  assign e3 = entry_flat[3*BYTE_W +: BYTE_W];
  assign e4 = entry_flat[4*BYTE_W +: BYTE_W];

  assign test_dac    = e0[7];
  assign test_mon    = e0[6];
  assign spare_tst   = {e0[2:0], e3[6], e3[7]};
  assign sep_hi_trim = e1[5:0];
  assign sep_lo_trim = e2[5:0];
  assign nr_sel      = e3[5];
  assign force_mono  = e3[4];
  assign sap_cond    = e3[3];
  assign mute_off    = e3[0];
  assign in_lvl_sel  = e4[7];
  assign att_bypass  = e4[5];
  assign force_st    = e4[4];
  assign att_lvl     = e4[3:0];

  assign unused_bits = ^{e0[5:3], e1[7:6], e2[7:6], e3[2:1], e4[6]};

endmodule

// File: rtl/avd_i2c_regfile_chk.sv
module avd_i2c_regfile_chk #(
  parameter int unsigned ENTRIES = 5,
  parameter int unsigned FLAT    = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scl_s,
  input logic            sda_oe,
  input logic            stop_det,
  input logic            wr_en,
  input logic [3:0]      wr_addr,
  input logic            por_flag,
  input logic [FLAT-1:0] entry_flat
);

  // R10: the data line only moves while the clock line is low
  a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R11: a stop leaves the line released
  a_r11_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R4: writes beyond the last entry leave every entry untouched
  a_r4_high_sub_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (32'(wr_addr) >= ENTRIES)) |=> $stable(entry_flat));

  // R9: the power-on flag is never set again after reset
  a_r9_por_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(por_flag));

endmodule

bind avd_i2c_regfile avd_i2c_regfile_chk #(
  .ENTRIES(avd_pkg::NUM_ENTRIES),
  .FLAT(avd_pkg::FLAT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .stop_det(stop_det), .wr_en(wr_en), .wr_addr(wr_addr),
  .por_flag(por_q), .entry_flat(entry_flat)
);

// File: tb/avd_i2c_regfile_tb_top.sv
`timescale 1ns/1ps
module avd_i2c_regfile_tb_top;

  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic det_stereo = 1'b0, det_sap = 1'b0, det_noise = 1'b0;
  logic test_dac, test_mon, nr_sel, force_mono, sap_cond, mute_off;
  logic force_st, att_bypass, in_lvl_sel;
  logic [4:0] spare_tst;
  logic [5:0] sep_hi_trim, sep_lo_trim;
  logic [3:0] att_lvl;

  always #10 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  avd_i2c_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .det_stereo(det_stereo), .det_sap(det_sap), .det_noise(det_noise),
    .test_dac(test_dac), .test_mon(test_mon), .spare_tst(spare_tst),
    .sep_hi_trim(sep_hi_trim), .sep_lo_trim(sep_lo_trim), .nr_sel(nr_sel),
    .force_mono(force_mono), .sap_cond(sap_cond), .mute_off(mute_off),
    .force_st(force_st), .att_bypass(att_bypass), .in_lvl_sel(in_lvl_sel),
    .att_lvl(att_lvl)
  );

  typedef struct {
    string      req;
    logic [7:0] val;
  } item_t;

  item_t      exp_q[$];
  logic [7:0] obs_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  int oe_viol = 0;
  bit done = 0;
  logic prev_oe = 1'b0;
  logic [7:0] model [5];

  function automatic logic [7:0] port_entry(input int idx);
    case (idx)
      0: port_entry = {test_dac, test_mon, 3'b000, spare_tst[4:2]};
      1: port_entry = {2'b00, sep_hi_trim};
      2: port_entry = {2'b00, sep_lo_trim};
      3: port_entry = {spare_tst[0], spare_tst[1], nr_sel, force_mono, sap_cond, 2'b00, mute_off};
      default: port_entry = {in_lvl_sel, 1'b0, att_bypass, force_st, att_lvl};
    endcase
  endfunction

  function automatic logic [7:0] spec_mask(input int idx);
    case (idx)
      0: spec_mask = 8'hC7;
      1, 2: spec_mask = 8'h3F;
      3: spec_mask = 8'hF9;
      default: spec_mask = 8'hBF;
    endcase
  endfunction

  task automatic expect_item(input string req, input logic [7:0] v);
    item_t it;
    it.req = req;
    it.val = v;
    exp_q.push_back(it);
  endtask

  task automatic observe(input logic [7:0] v);
    obs_q.push_back(v);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (obs_q.size() > 0 && exp_q.size() > 0) begin
      item_t it;
      logic [7:0] a;
      it = exp_q.pop_front();
      a = obs_q.pop_front();
      n_cmp++;
      if (a !== it.val) begin
        n_bad++;
        $display("FAIL %s actual=%02h expected=%02h", it.req, a, it.val);
      end
    end
  end

  // R10 watcher on the port
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== prev_oe) && scl_m) oe_viol++;
    prev_oe = sda_oe;
  end

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic b, output logic seen);
    waitq(); sda_m = b;
    waitq(); scl_m = 1'b1;
    waitq(); seen = sda_bus;
    waitq(); scl_m = 1'b0;
  endtask

  task automatic do_start();
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b0; waitq();
    scl_m = 1'b0;
  endtask

  task automatic do_stop();
    waitq(); sda_m = 1'b0;
    waitq(); scl_m = 1'b1;
    waitq(); sda_m = 1'b1;
    waitq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
    bit_xfer(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, s);
      b[i] = s;
    end
    bit_xfer(~host_ack, s);
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 5; i++) begin
      expect_item(req, model[i]);
      observe(port_entry(i));
    end
  endtask

  task automatic wr_burst(input logic [7:0] sub, input logic [7:0] d[], input string req);
    logic ak;
    logic [3:0] s;
    do_start();
    send_byte(8'h84, ak); expect_item("R1", 8'h01); observe({7'd0, ak});
    send_byte(sub, ak);
    s = sub[3:0];
    foreach (d[k]) begin
      send_byte(d[k], ak);
      expect_item(req, 8'h01); observe({7'd0, ak});
      if (s < 5) model[s] = d[k] & spec_mask(s);
      s = s + 4'd1;
    end
    do_stop();
  endtask

  initial begin
    logic ak;
    logic [7:0] rb;
    model[0] = 8'h00; model[1] = 8'h1F; model[2] = 8'h1F;
    model[3] = 8'h01; model[4] = 8'h09;

    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R6: reset values at the ports
    check_all("R6");

    // R5 / R7: burst from entry 0 through entry 4
    wr_burst(8'h00, '{8'hFF, 8'h2A, 8'h15, 8'hFF, 8'hFF}, "R5");
    check_all("R7");

    // R4: upper sub-address bits ignored, burst runs into entries 5 and 6
    wr_burst(8'hF3, '{8'h08, 8'h00, 8'hFF, 8'hFF}, "R4");
    check_all("R4");

    // R4: start directly at a missing entry
    wr_burst(8'h07, '{8'hFF}, "R4");
    check_all("R4");

    // R3: foreign address
    do_start();
    send_byte(8'h86, ak); expect_item("R3", 8'h00); observe({7'd0, ak});
    send_byte(8'h01, ak); expect_item("R3", 8'h00); observe({7'd0, ak});
    send_byte(8'hAA, ak); expect_item("R3", 8'h00); observe({7'd0, ak});
    do_stop();
    check_all("R3");

    // R2 / R8 / R9 / R12: two-byte status read
    det_sap = 1'b1; det_noise = 1'b0; det_stereo = 1'b1;
    do_start();
    send_byte(8'h85, ak); expect_item("R2", 8'h01); observe({7'd0, ak});
    recv_byte(1'b1, rb); expect_item("R9", 8'h83); observe(rb);
    recv_byte(1'b0, rb); expect_item("R12", 8'h81); observe(rb);
    do_stop();

    // R8: other flag pattern, power-on flag stays clear
    det_sap = 1'b0; det_noise = 1'b1; det_stereo = 1'b0;
    do_start();
    send_byte(8'h85, ak); expect_item("R2", 8'h01); observe({7'd0, ak});
    recv_byte(1'b0, rb); expect_item("R8", 8'h40); observe(rb);
    do_stop();

    // R11: write then repeated start into a read
    do_start();
    send_byte(8'h84, ak);
    send_byte(8'h01, ak);
    send_byte(8'h11, ak); model[1] = 8'h11;
    do_start();
    send_byte(8'h85, ak); expect_item("R11", 8'h01); observe({7'd0, ak});
    recv_byte(1'b0, rb); expect_item("R11", 8'h40); observe(rb);
    do_stop();
    check_all("R11");

    // R11: stop ends a burst, next byte is a sub-address again
    wr_burst(8'h02, '{8'h05}, "R11");
    wr_burst(8'h01, '{8'h22}, "R11");
    check_all("R11");

    // R10: line never changed while clock high
    expect_item("R10", 8'h00); observe(8'(oe_viol));

    repeat (20) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule